// File: doc/BRIEF.md
# MSI Directory Controller

This block is the parent side of a two-level coherence system. It owns the backing store for a small address space. For every pairing of a child cache and an address it keeps a directory entry: the child's MSI state and a flag that says whether a downgrade to that child is still outstanding.

Child traffic arrives one message at a time at the head of an inbound queue. A message is either a request to move a child up to a higher state, or a response that lowers a child's state. A response can answer a downgrade or be a voluntary write-back.

The controller grants an upgrade only once no sibling holds a conflicting copy. Until then it sends downgrade requests to the conflicting siblings, at most one outstanding per child. Responses are absorbed at once, and dirty data from a child in M is written back into memory. At most one outbound message leaves per cycle. The outbound side has no backpressure.

Top module: `msi_dir_ctrl`

## Requirements
- R1: After reset every directory state is I (2'd0), every wait flag is clear and every memory word is zero. With no inbound message, `out_valid` and `in_deq` are low.
- R2: A response at the head (`in_is_resp`=1) is dequeued in the same cycle it is presented, and no outbound message is produced for it.
- R3: On a response from child c for address a, memory word a takes `in_data` only if c's recorded state was M; otherwise memory is left unchanged. c's state becomes `in_state` and c's wait flag is cleared.
- R4: State codes are I=2'd0, S=2'd1, M=2'd2. A sibling in state x conflicts with a requested state y exactly for (M,M), (M,S) and (S,M).
- R5: A request from child c for state y is granted when no other child conflicts with y and c's own wait flag is clear. The grant is an outbound response to c carrying y (`out_is_resp`=1), the request is dequeued in that cycle, and y is recorded as c's state.
- R6: A grant carries data (`out_has_data`=1, `out_data` = memory word) only if the requester's recorded state was I. Otherwise `out_has_data`=0 and `out_data`=0.
- R7: While a request is not grantable, the controller picks the lowest-indexed other child that conflicts and has a clear wait flag. It sends that child a downgrade request (`out_is_resp`=0) targeting I when y is M, or S when y is S, and sets that child's wait flag.
- R8: No downgrade is sent to a child whose wait flag is set. Downgrades to different children go out on successive cycles, and when none is eligible the cycle is idle.
- R9: A request that is not granted stays at the head: `in_deq` is low for it.
- R10: For any address, at most one child is recorded in M.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Inbound queue head holds a message |
| in_is_resp | input | 1 | Head is a response (1) or a request (0) |
| in_src | input | CW | Child that sent the head message |
| in_addr | input | AW | Address of the head message |
| in_state | input | 2 | Requested state, or state after the child's downgrade |
| in_data | input | DW | Write-back data of a response |
| in_deq | output | 1 | Pop the inbound head this cycle |
| out_valid | output | 1 | Outbound message present |
| out_is_resp | output | 1 | Grant (1) or downgrade request (0) |
| out_dst | output | CW | Destination child |
| out_addr | output | AW | Address of the outbound message |
| out_state | output | 2 | Granted state or downgrade target |
| out_has_data | output | 1 | Grant carries memory data |
| out_data | output | DW | Memory data, zero when absent |

## Verification
The outbound message and `in_deq` follow the head message and the directory combinationally, so they are due in the same cycle the head is presented. Directory and memory changes become visible from the next cycle on. The bench drives each head message after a falling edge and compares every outbound field a few nanoseconds later, before the rising edge. Only after that edge does it update its own behavioural directory and memory. A written-back word or a changed state is therefore checked through the data and decisions of the grants that follow it.

// File: rtl/msi_dir_ctrl.sv
module msi_dir_ctrl #(
  parameter int N_CHILD = 3,
  parameter int N_ADDR  = 8,
  parameter int DW      = 32,
  localparam int CW = (N_CHILD > 1) ? $clog2(N_CHILD) : 1,
  localparam int AW = (N_ADDR > 1) ? $clog2(N_ADDR) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_is_resp,
  input  logic [CW-1:0] in_src,
  input  logic [AW-1:0] in_addr,
  input  logic [1:0]    in_state,
  input  logic [DW-1:0] in_data,
  output logic          in_deq,
  output logic          out_valid,
  output logic          out_is_resp,
  output logic [CW-1:0] out_dst,
  output logic [AW-1:0] out_addr,
  output logic [1:0]    out_state,
  output logic          out_has_data,
  output logic [DW-1:0] out_data
);
  localparam logic [1:0] ST_I = 2'd0, ST_S = 2'd1, ST_M = 2'd2;

  logic [N_CHILD-1:0][N_ADDR-1:0][1:0]  st;
  logic [N_CHILD-1:0][N_ADDR-1:0]       wt;
  logic [N_ADDR-1:0][DW-1:0]            mem;

  logic [N_CHILD-1:0] conf;
  logic               req, grant, dng_hit;
  logic [CW-1:0]      dng_idx;
  logic [1:0]         src_st;

  function automatic logic clash(input logic [1:0] have, input logic [1:0] want);
    return (have == ST_M && want != ST_I) || (have == ST_S && want == ST_M);
  endfunction

  assign req    = in_valid && !in_is_resp;
  assign src_st = st[in_src][in_addr];

  always_comb begin
    for (int i = 0; i < N_CHILD; i++)
      conf[i] = (CW'(i) != in_src) && clash(st[i][in_addr], in_state);
  end

  assign grant = req && (conf == '0) && !wt[in_src][in_addr];

  always_comb begin
    dng_hit = 1'b0;
    dng_idx = '0;
    for (int i = N_CHILD - 1; i >= 0; i--) begin
      if (conf[i] && !wt[i][in_addr]) begin
        dng_hit = req && !grant;
        dng_idx = CW'(i);
      end
    end
  end

  assign in_deq       = in_valid && (in_is_resp || grant);
  assign out_valid    = grant || dng_hit;
  assign out_is_resp  = grant;
  assign out_dst      = grant ? in_src : dng_idx;
  assign out_addr     = in_addr;
  assign out_state    = grant ? in_state : ((in_state == ST_M) ? ST_I : ST_S);
  assign out_has_data = grant && (src_st == ST_I);
  assign out_data     = out_has_data ? mem[in_addr] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= '0;
      wt  <= '0;
      mem <= '0;
    end else begin
      if (in_valid && in_is_resp) begin
        if (src_st == ST_M) mem[in_addr] <= in_data;
        st[in_src][in_addr] <= in_state;
        wt[in_src][in_addr] <= 1'b0;
      end
      if (grant) st[in_src][in_addr] <= in_state;
      if (dng_hit) wt[dng_idx][in_addr] <= 1'b1;
    end
  end
endmodule

module msi_dir_ctrl_chk #(
  parameter int N_CHILD = 3,
  parameter int N_ADDR  = 8,
  localparam int CW = (N_CHILD > 1) ? $clog2(N_CHILD) : 1,
  localparam int AW = (N_ADDR > 1) ? $clog2(N_ADDR) : 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_is_resp,
  input logic [CW-1:0] in_src,
  input logic [1:0]    in_state,
  input logic          in_deq,
  input logic          out_valid,
  input logic          out_is_resp,
  input logic [CW-1:0] out_dst,
  input logic [AW-1:0] out_addr,
  input logic [1:0]    out_state,
  input logic          out_has_data,
  input logic [N_CHILD-1:0][N_ADDR-1:0][1:0] st,
  input logic [N_CHILD-1:0][N_ADDR-1:0]      wt
);
  logic multi_m;
  always_comb begin
    multi_m = 1'b0;
    for (int a = 0; a < N_ADDR; a++) begin
      int cnt;
      cnt = 0;
      for (int c = 0; c < N_CHILD; c++) if (st[c][a] == 2'd2) cnt++;
      if (cnt > 1) multi_m = 1'b1;
    end
  end

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> (!out_valid && !in_deq));
  // R2
  resp_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_is_resp) |-> (in_deq && !out_valid));
  // R5
  grant_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_is_resp) |-> (in_deq && out_dst == in_src && out_state == in_state));
  // R6
  data_only_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_has_data |-> (out_valid && out_is_resp));
  // R7
  dng_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_is_resp) |-> (out_state == ((in_state == 2'd2) ? 2'd0 : 2'd1)));
  // R8
  dng_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_is_resp) |-> (!wt[out_dst][out_addr] && out_dst != in_src));
  // R8
  dng_marks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_is_resp) |=> wt[$past(out_dst)][$past(out_addr)]);
  // R9
  hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_is_resp) |-> !in_deq);
  // R10
  single_owner_chk: assert property (@(posedge clk) disable iff (!rst_n) !multi_m);
endmodule

bind msi_dir_ctrl msi_dir_ctrl_chk #(.N_CHILD(N_CHILD), .N_ADDR(N_ADDR)) u_chk (.*);

// File: tb/msi_dir_ctrl_test.sv
`timescale 1ns/1ps
module msi_dir_ctrl_test;
  localparam int NC = 3, NA = 8, DW = 32, CW = 2, AW = 3;
  localparam int I = 0, S = 1, M = 2;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_is_resp = 0;
  logic [CW-1:0] in_src = 0;
  logic [AW-1:0] in_addr = 0;
  logic [1:0] in_state = 0;
  logic [DW-1:0] in_data = 0;
  logic in_deq, out_valid, out_is_resp, out_has_data;
  logic [CW-1:0] out_dst;
  logic [AW-1:0] out_addr;
  logic [1:0] out_state;
  logic [DW-1:0] out_data;

  int checks = 0, errors = 0;
  int ms [NC][NA];
  int mw [NC][NA];
  logic [DW-1:0] mm [NA];

  always #5 clk = ~clk;

  msi_dir_ctrl #(.N_CHILD(NC), .N_ADDR(NA), .DW(DW)) uut (.*);

  function automatic bit conflicts(int have, int want);
    // R4 table
    if (have == M && (want == M || want == S)) return 1;
    if (have == S && want == M) return 1;
    return 0;
  endfunction

  task automatic step(input bit v, input bit rsp, input int src, input int a,
                      input int y, input logic [DW-1:0] d, output bit popped);
    bit e_deq, e_ov, e_gr, e_hd, blocked, ok;
    int e_dst, e_st, dst;
    logic [DW-1:0] e_data;
    string tag;
    @(negedge clk);
    in_valid = v; in_is_resp = rsp; in_src = CW'(src); in_addr = AW'(a);
    in_state = 2'(y); in_data = d;
    e_deq = 0; e_ov = 0; e_gr = 0; e_hd = 0; e_dst = 0; e_st = 0; e_data = 0;
    dst = -1; tag = "R1";
    if (v && rsp) begin
      e_deq = 1; tag = "R2";
    end else if (v) begin
      blocked = (mw[src][a] != 0);
      for (int c = 0; c < NC; c++)
        if (c != src && conflicts(ms[c][a], y)) blocked = 1;
      if (!blocked) begin
        e_deq = 1; e_ov = 1; e_gr = 1; e_dst = src; e_st = y;
        e_hd = (ms[src][a] == I); e_data = e_hd ? mm[a] : '0;
        tag = "R5/R6";
      end else begin
        tag = "R9/R8";
        for (int c = 0; c < NC; c++)
          if (dst < 0 && c != src && conflicts(ms[c][a], y) && mw[c][a] == 0) dst = c;
        if (dst >= 0) begin
          e_ov = 1; e_dst = dst; e_st = (y == M) ? I : S; tag = "R7";
        end
      end
    end
    #4;
    ok = (in_deq == e_deq) && (out_valid == e_ov);
    if (e_ov)
      ok = ok && (out_is_resp == e_gr) && (int'(out_dst) == e_dst) && (int'(out_addr) == a)
           && (int'(out_state) == e_st) && (out_has_data == e_hd) && (out_data == e_data);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got deq=%0b ov=%0b rsp=%0b dst=%0d st=%0d hd=%0b data=%h, want deq=%0b ov=%0b rsp=%0b dst=%0d st=%0d hd=%0b data=%h",
               tag, in_deq, out_valid, out_is_resp, out_dst, out_state, out_has_data, out_data,
               e_deq, e_ov, e_gr, e_dst, e_st, e_hd, e_data);
    end
    @(posedge clk);
    if (v && rsp) begin
      if (ms[src][a] == M) mm[a] = d;   // R3
      ms[src][a] = y; mw[src][a] = 0;
    end else if (e_gr) ms[src][a] = y;
    else if (dst >= 0) mw[dst][a] = 1;
    popped = e_deq;
  endtask

  task automatic req(input int src, input int a, input int y, input int cyc);
    bit p;
    for (int k = 0; k < cyc; k++) begin
      step(1, 0, src, a, y, '0, p);
      if (p) break;
    end
  endtask

  task automatic rsp(input int src, input int a, input int y, input logic [DW-1:0] d);
    bit p;
    step(1, 1, src, a, y, d, p);
  endtask

  task automatic idle(input int n);
    bit p;
    for (int k = 0; k < n; k++) step(0, 0, 0, 0, 0, '0, p);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got hung run, want completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int c = 0; c < NC; c++) for (int a = 0; a < NA; a++) begin ms[c][a] = I; mw[c][a] = 0; end
    for (int a = 0; a < NA; a++) mm[a] = '0;
    repeat (3) @(posedge clk);
    rst_n = 1;
    idle(2);                          // R1 quiet after reset
    req(0, 3, M, 1);                  // R5 R6 grant from zeroed memory
    req(1, 3, S, 2);                  // R7 downgrade c0 to S, then R8 idle
    rsp(0, 3, S, 32'hAAAA5555);       // R2 R3 dirty write-back
    req(1, 3, S, 1);                  // R6 data returns the written word
    req(2, 3, M, 3);                  // R7 R8 successive downgrades to c0, c1
    rsp(1, 3, I, 32'h0000DEAD);       // R3 clean: data ignored
    rsp(0, 3, I, 32'h0000BEEF);       // R3 clean: data ignored
    req(2, 3, M, 1);                  // R6 still AAAA5555
    req(2, 3, S, 1);                  // R6 owner downgrade: no data
    req(0, 3, S, 1);                  // R4 S,S compatible
    req(1, 5, M, 1);
    req(0, 5, M, 2);                  // R7 to c1 target I, R9 held
    req(1, 5, S, 2);                  // R5 own wait flag blocks, idle
    rsp(1, 5, I, 32'h00001234);       // R3 dirty
    req(1, 5, S, 1);                  // R6 data 1234
    req(0, 5, M, 2);                  // R7 downgrade c1 from S
    rsp(1, 5, I, 32'h0);
    req(0, 5, M, 1);                  // R10 single owner kept
    rsp(2, 3, I, 32'hFFFF0000);       // voluntary write-back, c2 in S
    req(1, 3, M, 3);
    idle(2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule